// File: doc/BRIEF.md
# Soft-Start Sweep Oscillator for a Half-Bridge

This block is a digital numerically controlled oscillator that makes the 50% duty-cycle switching reference for a half-bridge converter. A control code stands in for the voltage on a timing capacitor, with 128 codes equal to 5 V. At power-up an internal ramp raises the code linearly from zero. The frequency word follows a falling line, so the switching frequency starts high and sweeps down to its floor. This eases the inrush current of a cold filament load.

Once the ramp has stayed above its end level for a debounce window, a sticky end-of-soft-start flag sets. The oscillator then changes to a narrower run range. In that range the code comes from a load-current measurement, so a light load gives a higher frequency and a lower output voltage. A triangular ripple is subtracted from the load code to spread the spectrum at twice line rate. A force-minimum input holds the oscillator at its floor frequency while an external fault timer uses the capacitor. A restart input sends the block back to the start of soft-start.

Top module: `sweep_nco`

## Requirements
- R1: During a synchronous active-low reset the frequency word is 1300, `phase` is 0 and `ss_done` is 0.
- R2: After reset or restart the internal code is floor(n/4) after n clocks, saturating at 141. While `ss_done` is 0 and `force_min` is 0, the frequency word one clock later is 1300 - ((960*min(code,128))>>7). So it falls from 1300 to 340.
- R3: `ss_done` sets on the clock edge where the code has been at or above 133 for 20 consecutive edges, which is 552 edges after the ramp starts. It then stays set until reset or restart.
- R4: A high `restart_ss` at a clock edge clears the ramp, the debounce count, the ripple and `ss_done`. The next edge loads a frequency word of 1300.
- R5: While `ss_done` is 1 and `force_min` is 0, the frequency word one clock later is 700 - ((360*min(e,128))>>7). Here e = max(min(load_code,141) - ripple, 0), so code 0 gives 700 and code 128 gives 340.
- R6: In run mode every load code above 141 acts as 141. With the ripple at its peak of 14, a load of 255 gives a frequency word of 343.
- R7: The ripple is a triangle with values 0,1,…,14,13,…,0. It changes by one every 2 clocks that `ss_done` is set, starts at 0 when `ss_done` rises, and repeats every 56 clocks.
- R8: A high `force_min` at an edge loads a frequency word of 340 in both modes. The soft-start ramp keeps running underneath it.
- R9: A 14-bit phase accumulator adds the registered frequency word on every clock. `phase` is its most significant bit, which gives a 50% duty cycle.
- R10: The frequency word always lies in [340, 1300], and with no restart or force it never rises during soft-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart_ss | input | 1 | Synchronous return to the start of soft-start |
| load_code | input | 8 | Measured load current code (128 = full load) |
| force_min | input | 1 | Hold the oscillator at its floor frequency |
| phase | output | 1 | 50% duty-cycle switching reference |
| ss_done | output | 1 | Sticky end-of-soft-start flag |
| freq_word | output | 14 | Registered phase increment now in use |

## Verification
The bench checks the debounce edge exactly. It restarts once partway through the window, which shows that a ramp interrupted before 20 edges never sets the flag; a design that latched on the first crossing would raise `ss_done` early. A sweep over all 256 load codes, held across the ripple cycle, tests the clamp at 141. A design that skipped the clamp would show 340 instead of 343 at full-scale load with the ripple at its peak. Force pulses in both modes and a restart from run mode catch a floor that applies in one mode only, and a flag that does not clear.

// File: rtl/sweep_nco_pkg.sv
// Shared types and the piecewise-linear code-to-increment map.
// Assumes the code full-scale point is a power of two.
package sweep_nco_pkg;

    typedef enum logic [1:0] {
        RANGE_SOFT  = 2'd0,
        RANGE_RUN   = 2'd1,
        RANGE_FLOOR = 2'd2
    } osc_range_e;

    // Falling line from hi at code 0 to lo at code 2**full_log2, flat beyond it.
    function automatic logic [31:0] lin_map(input logic [31:0] hi,
                                            input logic [31:0] lo,
                                            input logic [31:0] code,
                                            input int          full_log2);
        logic [31:0] knee;
        logic [31:0] c;
        knee = 32'd1 << full_log2;
        c    = (code > knee) ? knee : code;
        return hi - (((hi - lo) * c) >> full_log2);
    endfunction

endpackage

// File: rtl/sweep_ramp.sv
// Soft-start code ramp with debounced, sticky end-of-ramp flag.
// Assumes RAMP_DIV >= 2 and DEB_CYC >= 1; restart acts like a local reset.
module sweep_ramp #(
    parameter int CODE_W     = 8,
    parameter int RAMP_DIV   = 4,
    parameter int END_CODE   = 133,
    parameter int CLAMP_CODE = 141,
    parameter int DEB_CYC    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    output logic [CODE_W-1:0] code,
    output logic              done
);
    localparam int DIV_W = $clog2(RAMP_DIV + 1);
    localparam int DEB_W = $clog2(DEB_CYC + 1);
    localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(RAMP_DIV - 1);
    localparam logic [DEB_W-1:0]  DEB_LAST = DEB_W'(DEB_CYC - 1);
    localparam logic [CODE_W-1:0] END_C    = CODE_W'(END_CODE);
    localparam logic [CODE_W-1:0] CLAMP_C  = CODE_W'(CLAMP_CODE);

    logic [DIV_W-1:0] pre;
    logic [DEB_W-1:0] dbc;

    // Raise the code by one every RAMP_DIV clocks up to the clamp.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre  <= '0;
            code <= '0;
        end else if (pre == DIV_LAST) begin
            pre <= '0;
            if (code < CLAMP_C) code <= code + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // Latch done once the code has held at or above the end level long enough.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            dbc  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (code >= END_C) begin
                if (dbc == DEB_LAST) done <= 1'b1;
                else                 dbc  <= dbc + 1'b1;
            end else begin
                dbc <= '0;
            end
        end
    end

endmodule

// File: rtl/line_dither.sv
// Triangular ripple 0..AMP..0 stepping every DIV enabled clocks.
// Assumes AMP >= 1 and DIV >= 1; held at zero while disabled.
module line_dither #(
    parameter int AMP   = 14,
    parameter int DIV   = 2,
    parameter int RIP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [RIP_W-1:0] ripple
);
    localparam int CNT_W = $clog2(DIV + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
    localparam logic [RIP_W-1:0] PEAK     = RIP_W'(AMP);

    logic [CNT_W-1:0] cnt;
    logic             going_up;

    // Walk the triangle up to the peak and back down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt      <= '0;
            ripple   <= '0;
            going_up <= 1'b1;
        end else if (cnt == CNT_LAST) begin
            cnt <= '0;
            if (going_up) begin
                ripple <= ripple + 1'b1;
                if (ripple + 1'b1 == PEAK) going_up <= 1'b0;
            end else begin
                ripple <= ripple - 1'b1;
                if (ripple == RIP_W'(1)) going_up <= 1'b1;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/phase_acc.sv
// Registered increment plus phase accumulator; output is the accumulator MSB.
// Assumes the increment is below half the accumulator range.
module phase_acc #(
    parameter int ACC_W    = 14,
    parameter int RST_WORD = 1300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] next_word,
    output logic [ACC_W-1:0] word,
    output logic             phase
);
    logic [ACC_W-1:0] acc;

    // Register the increment and advance the phase by the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= ACC_W'(RST_WORD);
            acc  <= '0;
        end else begin
            word <= next_word;
            acc  <= acc + word;
        end
    end

    assign phase = acc[ACC_W-1];

endmodule

// File: rtl/sweep_nco.sv
// Top: selects the oscillator range and code, maps code to increment, drives the NCO.
// Assumes 2**FULL_LOG2 codes equal the full-load point and INC_MIN is the common floor.
module sweep_nco
    import sweep_nco_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int ACC_W       = 14,
    parameter int FULL_LOG2   = 7,
    parameter int END_CODE    = 133,
    parameter int CLAMP_CODE  = 141,
    parameter int RAMP_DIV    = 4,
    parameter int DEB_CYC     = 20,
    parameter int DITH_AMP    = 14,
    parameter int DITH_DIV    = 2,
    parameter int INC_SOFT_HI = 1300,
    parameter int INC_RUN_HI  = 700,
    parameter int INC_MIN     = 340
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_ss,
    input  logic [CODE_W-1:0] load_code,
    input  logic              force_min,
    output logic              phase,
    output logic              ss_done,
    output logic [ACC_W-1:0]  freq_word
);
    localparam int RIP_W = $clog2(DITH_AMP + 1);
    localparam logic [CODE_W-1:0] CLAMP_C = CODE_W'(CLAMP_CODE);

    logic [CODE_W-1:0] ramp_code;
    logic [RIP_W-1:0]  ripple;
    logic [CODE_W-1:0] load_clamped;
    logic [CODE_W-1:0] run_code;
    logic [ACC_W-1:0]  next_word;
    osc_range_e        range_sel;

    sweep_ramp #(
        .CODE_W(CODE_W), .RAMP_DIV(RAMP_DIV), .END_CODE(END_CODE),
        .CLAMP_CODE(CLAMP_CODE), .DEB_CYC(DEB_CYC)
    ) i_ramp (
        .clk(clk), .rst_n(rst_n), .restart(restart_ss),
        .code(ramp_code), .done(ss_done)
    );

    line_dither #(
        .AMP(DITH_AMP), .DIV(DITH_DIV), .RIP_W(RIP_W)
    ) i_dither (
        .clk(clk), .rst_n(rst_n), .en(ss_done), .ripple(ripple)
    );

    // Pick the active range: forced floor beats run, run beats soft-start.
    always_comb begin
        if (force_min)    range_sel = RANGE_FLOOR;
        else if (ss_done) range_sel = RANGE_RUN;
        else              range_sel = RANGE_SOFT;
    end

    // Clamp the load code, then subtract the ripple with a floor at zero.
    always_comb begin
        load_clamped = (load_code > CLAMP_C) ? CLAMP_C : load_code;
        run_code = (load_clamped > CODE_W'(ripple)) ? load_clamped - CODE_W'(ripple) : '0;
    end

    // Map the selected code onto the increment of the active range.
    always_comb begin
        unique case (range_sel)
            RANGE_RUN:   next_word = ACC_W'(lin_map(32'(INC_RUN_HI), 32'(INC_MIN),
                                                    32'(run_code), FULL_LOG2));
            RANGE_SOFT:  next_word = ACC_W'(lin_map(32'(INC_SOFT_HI), 32'(INC_MIN),
                                                    32'(ramp_code), FULL_LOG2));
            default:     next_word = ACC_W'(INC_MIN);
        endcase
    end

    phase_acc #(
        .ACC_W(ACC_W), .RST_WORD(INC_SOFT_HI)
    ) i_acc (
        .clk(clk), .rst_n(rst_n), .next_word(next_word),
        .word(freq_word), .phase(phase)
    );

endmodule

// File: rtl/sweep_nco_chk.sv
// Property checker for sweep_nco, attached with bind.
// Assumes the same increment parameters as the instance it watches.
module sweep_nco_chk #(
    parameter int ACC_W       = 14,
    parameter int INC_SOFT_HI = 1300,
    parameter int INC_RUN_HI  = 700,
    parameter int INC_MIN     = 340
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart_ss,
    input logic             force_min,
    input logic             ss_done,
    input logic [ACC_W-1:0] freq_word
);
    localparam logic [ACC_W-1:0] W_MIN  = ACC_W'(INC_MIN);
    localparam logic [ACC_W-1:0] W_RUN  = ACC_W'(INC_RUN_HI);
    localparam logic [ACC_W-1:0] W_SOFT = ACC_W'(INC_SOFT_HI);

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done && !restart_ss |=> ss_done);                              // R3
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart_ss |=> !ss_done);                                         // R4
    AST_RUN_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |=> freq_word <= W_RUN);                                  // R5
    AST_FORCED_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        force_min |=> freq_word == W_MIN);                                // R8
    AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        freq_word >= W_MIN && freq_word <= W_SOFT);                       // R10
    AST_SOFT_SWEEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_done && !restart_ss && !force_min) ##1 (!ss_done && !force_min)
        |=> freq_word <= $past(freq_word));                               // R10

endmodule

bind sweep_nco sweep_nco_chk #(
    .ACC_W(ACC_W), .INC_SOFT_HI(INC_SOFT_HI),
    .INC_RUN_HI(INC_RUN_HI), .INC_MIN(INC_MIN)
) i_chk (
    .clk(clk), .rst_n(rst_n), .restart_ss(restart_ss), .force_min(force_min),
    .ss_done(ss_done), .freq_word(freq_word)
);

// File: tb/test_sweep_nco.sv
`timescale 1ns/1ps
// Self-checking bench: models ramp, debounce, ripple, map and accumulator arithmetically.
module test_sweep_nco;
    localparam int ND = 133 * 4 + 20;   // edges until the end flag sets

    logic        clk = 1'b0;
    logic        rst_n;
    logic        restart_ss;
    logic [7:0]  load_code;
    logic        force_min;
    logic        phase;
    logic        ss_done;
    logic [13:0] freq_word;

    int          n_edge;
    logic [13:0] acc_m;
    logic [13:0] fw_m;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    sweep_nco i_sweep_nco (
        .clk(clk), .rst_n(rst_n), .restart_ss(restart_ss), .load_code(load_code),
        .force_min(force_min), .phase(phase), .ss_done(ss_done), .freq_word(freq_word)
    );

    function automatic int ss_map(int c);
        int cc = (c > 128) ? 128 : c;
        return 1300 - ((960 * cc) >> 7);
    endfunction

    function automatic int run_map(int e);
        int ee = (e > 128) ? 128 : e;
        return 700 - ((360 * ee) >> 7);
    endfunction

    function automatic int code_at(int n);
        int c = n / 4;
        return (c > 141) ? 141 : c;
    endfunction

    function automatic int ripple_at(int n);
        int m = ((n - ND) / 2) % 28;
        return (m <= 14) ? m : 28 - m;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at n=%0d", tag, act, exp, n_edge);
        end
    endtask

    // One clock: predict from pre-edge state and inputs, then compare after the edge.
    task automatic tick(string tag);
        int nxt;
        int cl;
        int eff;
        if (force_min) nxt = 340;
        else if (n_edge >= ND) begin
            cl  = (load_code > 141) ? 141 : int'(load_code);
            eff = cl - ripple_at(n_edge);
            if (eff < 0) eff = 0;
            nxt = run_map(eff);
        end else nxt = ss_map(code_at(n_edge));
        acc_m  = acc_m + fw_m;
        n_edge = restart_ss ? 0 : n_edge + 1;
        @(posedge clk);
        @(negedge clk);
        fw_m = 14'(nxt);
        check(tag, int'(freq_word), nxt);
        check("R3", int'(ss_done), (n_edge >= ND) ? 1 : 0);
        check("R9", int'(phase), int'(acc_m[13]));
        check("R10", (freq_word >= 340 && freq_word <= 1300) ? 1 : 0, 1);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        string t;
        rst_n = 1'b0; restart_ss = 1'b0; force_min = 1'b0; load_code = 8'd0;
        n_edge = 0; acc_m = '0; fw_m = 14'd1300;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", int'(freq_word), 1300);
        check("R1", int'(phase), 0);
        check("R1", int'(ss_done), 0);
        rst_n = 1'b1;

        // R2 ramp, then R4 restart inside the debounce window.
        repeat (540) tick("R2");
        restart_ss = 1'b1; tick("R4"); restart_ss = 1'b0;
        tick("R4");
        repeat (ND + 60) tick("R2");

        // R5/R6 sweep of every load code across the ripple cycle.
        for (int v = 0; v < 256; v++) begin
            load_code = 8'(v);
            t = (v > 141) ? "R6" : "R5";
            repeat (30) tick(t);
        end
        load_code = 8'd100;
        repeat (120) tick("R7");

        // R8 floor in run mode.
        force_min = 1'b1; repeat (10) tick("R8");
        force_min = 1'b0; repeat (5) tick("R8");
        load_code = 8'd255;
        repeat (60) tick("R6");

        // R4 restart from run, R8 floor during soft-start, then a full ramp.
        restart_ss = 1'b1; tick("R4"); restart_ss = 1'b0;
        tick("R4");
        repeat (100) tick("R2");
        force_min = 1'b1; repeat (20) tick("R8");
        force_min = 1'b0;
        repeat (600) tick("R2");

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule